// File: doc/BRIEF.md
# FEC Operating-State and Status-Indication Controller

This block keeps track of the forward-error-correction operating state on both sides of a line. On the transmit side it registers the encoder state chosen by management. That state is one of three: coding active, coding off with the encoder latency kept, or coding off with the encoder latency removed. From this state the block builds the status byte that goes into row 3 of each frame. Only the first block group carries a meaningful two-bit code. Every other group sends an all-zero byte.

On the receive side the block reads the two status bits from the received status byte before any decoding happens. It remembers the last valid code it saw. At row boundaries it moves the decoder between the correcting state and the delayed pass-through state, so that a code block is never handled in two modes. When it makes one of these seamless changes it raises a one-cycle flag. Management alone can force or release the no-delay bypass state. That change alters path latency and takes effect at once.

Top module: `fec_status_ctl`

## Requirements
- R1: After reset the encoder and decoder states both read 2 (off, delay kept). The stored received status is "off". The hitless and invalid flags are 0.
- R2: A management encoder code of 1, 2 or 3 on `enc_mode_i` becomes `enc_state_o` one clock later. Code 0 is ignored and the state is held.
- R3: `tx_status_byte_o` for group index 0 is 8'h01 when the encoder state is 1 and 8'h00 otherwise. The code sits in bits [1:0] and bits [7:2] are zero. Every other group index gets 8'h00, so the codes 2'b10 and 2'b11 never appear.
- R4: `enc_delay_sel_o` is 1 in encoder states 1 and 2 and 0 in state 3.
- R5: On a clock with `rx_status_stb_i` high, bits [1:0] of `rx_status_byte_i` are sampled. Code 2'b01 means "on" and 2'b00 means "off". Bits [7:2] have no effect.
- R6: A received code of 2'b10 or 2'b11 leaves the stored status unchanged. It raises `rx_invalid_o` for exactly the one cycle after the strobe.
- R7: Outside bypass, the decoder state changes only on a clock with `row_start_i` high. It then becomes 1 if the stored status (as held before that edge) is "on", and 2 if it is "off".
- R8: `hitless_o` is high for exactly the cycle in which the decoder state has just changed between 1 and 2. It is never high for a change into or out of state 3.
- R9: While `dec_bypass_i` is high, the decoder state is 3 one clock later, whatever the row or status inputs are. After bypass is released, the state is 2 one clock later. Only a later row boundary can then take it to 1.
- R10: `dec_corr_en_o` is 1 only in decoder state 1. `dec_delay_sel_o` is 1 in decoder states 1 and 2 and 0 in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_mode_i | input | 2 | Management encoder state request (0 = hold) |
| tx_group_i | input | GRP_W | Index of the block group whose status byte is being sent |
| tx_status_byte_o | output | 8 | Status byte to insert for that group |
| enc_state_o | output | 2 | Encoder state 1/2/3 |
| enc_delay_sel_o | output | 1 | Encoder latency path kept |
| rx_status_stb_i | input | 1 | Received row-3 status byte of group 0 is valid |
| rx_status_byte_i | input | 8 | Received status byte |
| row_start_i | input | 1 | First cycle of a row |
| dec_bypass_i | input | 1 | Management request for the no-delay bypass |
| dec_state_o | output | 2 | Decoder state 1/2/3 |
| dec_corr_en_o | output | 1 | Correction enabled |
| dec_delay_sel_o | output | 1 | Decoder latency path kept |
| hitless_o | output | 1 | Seamless 1/2 change just applied |
| rx_invalid_o | output | 1 | Invalid status code received |

## Verification
The bench builds the block with NUM_GROUPS = 4. This lets group indices 1 to 3 reach the zero-byte path, next to the group-0 code path. Random strobes, row starts and bypass requests often fall on the same clock. This exercises the rule that a row boundary applies the status held before the edge, and that bypass overrides a row boundary. Random upper bits in the received byte, together with the invalid codes, show that only bits [1:0] matter.

// File: rtl/fec_ctl_pkg.sv
package fec_ctl_pkg;

    typedef enum logic [1:0] {
        ST_RSVD    = 2'd0,
        ST_ON      = 2'd1,
        ST_OFF_DLY = 2'd2,
        ST_OFF_BYP = 2'd3
    } fec_state_e;

    localparam logic [1:0] FSI_OFF = 2'b00;
    localparam logic [1:0] FSI_ON  = 2'b01;

    function automatic logic fsi_is_valid(input logic [1:0] code);
        return (code == FSI_OFF) || (code == FSI_ON);
    endfunction

    function automatic logic state_keeps_delay(input fec_state_e s);
        return (s == ST_ON) || (s == ST_OFF_DLY);
    endfunction

endpackage

// File: rtl/fec_tx_status.sv
module fec_tx_status
    import fec_ctl_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       enc_mode_i,
    input  logic [GRP_W-1:0] grp_i,
    output fec_state_e       enc_state_o,
    output logic             enc_delay_sel_o,
    output logic [7:0]       status_byte_o
);
    fec_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_OFF_DLY;
        else if (enc_mode_i != 2'd0)
            state_q <= fec_state_e'(enc_mode_i);
    end

    always_comb begin
        status_byte_o = 8'h00;
        if (grp_i == '0)
            status_byte_o[1:0] = (state_q == ST_ON) ? FSI_ON : FSI_OFF;
    end

    assign enc_state_o     = state_q;
    assign enc_delay_sel_o = state_keeps_delay(state_q);

    // R3: a reserved code never leaves the transmitter
    p_tx_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
        status_byte_o[1] == 1'b0 && status_byte_o[7:2] == 6'd0);

    // R2: a zero request holds the encoder state
    p_enc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (enc_mode_i == 2'd0) |=> $stable(state_q));

endmodule

// File: rtl/fec_rx_status.sv
module fec_rx_status
    import fec_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb_i,
    input  logic [7:0] byte_i,
    output logic       pend_on_o,
    output logic       invalid_o
);
    logic [1:0] code;
    logic       pend_q;
    logic       inv_q;

    assign code = byte_i[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            inv_q  <= 1'b0;
        end else begin
            inv_q <= stb_i && !fsi_is_valid(code);
            if (stb_i && fsi_is_valid(code))
                pend_q <= (code == FSI_ON);
        end
    end

    assign pend_on_o = pend_q;
    assign invalid_o = inv_q;

    // R6: an invalid code leaves the stored status alone
    p_invalid_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (stb_i && byte_i[1]) |=> ($stable(pend_q) && inv_q));

    // R5: without a strobe the stored status does not move
    p_no_strobe_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> ($stable(pend_q) && !inv_q));

endmodule

// File: rtl/fec_dec_fsm.sv
module fec_dec_fsm
    import fec_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bypass_i,
    input  logic       row_start_i,
    input  logic       pend_on_i,
    output fec_state_e state_o,
    output logic       hitless_o
);
    fec_state_e state_q, state_d;
    logic       hit_q;

    always_comb begin
        state_d = state_q;
        if (bypass_i)
            state_d = ST_OFF_BYP;
        else if (state_q == ST_OFF_BYP || state_q == ST_RSVD)
            state_d = ST_OFF_DLY;
        else if (row_start_i)
            state_d = pend_on_i ? ST_ON : ST_OFF_DLY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF_DLY;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            hit_q   <= (state_d != state_q) && state_keeps_delay(state_d)
                       && state_keeps_delay(state_q);
        end
    end

    assign state_o   = state_q;
    assign hitless_o = hit_q;

    // R9: bypass request wins next cycle
    p_bypass_enter_r9: assert property (@(posedge clk) disable iff (rst)
        bypass_i |=> (state_q == ST_OFF_BYP));

    // R9: leaving bypass lands in the delayed pass-through state
    p_bypass_leave_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFF_BYP && !bypass_i) |=> (state_q == ST_OFF_DLY));

    // R7: no change inside a row while out of bypass
    p_row_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        (!row_start_i && !bypass_i && state_q != ST_OFF_BYP) |=> $stable(state_q));

    // R7: correction entered only with an "on" status held
    p_enter_on_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_ON && !pend_on_i) |=> (state_q != ST_ON));

    // R8: the flag marks only a seamless 1/2 change
    p_hitless_r8: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> (state_q != ST_OFF_BYP && $past(state_q) != ST_OFF_BYP
                   && state_q != $past(state_q)));

endmodule

// File: rtl/fec_status_ctl.sv
module fec_status_ctl
    import fec_ctl_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       enc_mode_i,
    input  logic [GRP_W-1:0] tx_group_i,
    output logic [7:0]       tx_status_byte_o,
    output logic [1:0]       enc_state_o,
    output logic             enc_delay_sel_o,
    input  logic             rx_status_stb_i,
    input  logic [7:0]       rx_status_byte_i,
    input  logic             row_start_i,
    input  logic             dec_bypass_i,
    output logic [1:0]       dec_state_o,
    output logic             dec_corr_en_o,
    output logic             dec_delay_sel_o,
    output logic             hitless_o,
    output logic             rx_invalid_o
);
    fec_state_e enc_state, dec_state;
    logic       pend_on;

    fec_tx_status #(.NUM_GROUPS(NUM_GROUPS)) u_tx (
        .clk             (clk),
        .rst             (rst),
        .enc_mode_i      (enc_mode_i),
        .grp_i           (tx_group_i),
        .enc_state_o     (enc_state),
        .enc_delay_sel_o (enc_delay_sel_o),
        .status_byte_o   (tx_status_byte_o)
    );

    fec_rx_status u_rx (
        .clk       (clk),
        .rst       (rst),
        .stb_i     (rx_status_stb_i),
        .byte_i    (rx_status_byte_i),
        .pend_on_o (pend_on),
        .invalid_o (rx_invalid_o)
    );

    fec_dec_fsm u_dec (
        .clk         (clk),
        .rst         (rst),
        .bypass_i    (dec_bypass_i),
        .row_start_i (row_start_i),
        .pend_on_i   (pend_on),
        .state_o     (dec_state),
        .hitless_o   (hitless_o)
    );

    assign enc_state_o     = enc_state;
    assign dec_state_o     = dec_state;
    assign dec_corr_en_o   = (dec_state == ST_ON);
    assign dec_delay_sel_o = state_keeps_delay(dec_state);

    // R10: correction and bypass never coincide
    p_corr_not_bypass_r10: assert property (@(posedge clk) disable iff (rst)
        !(dec_corr_en_o && !dec_delay_sel_o));

endmodule

// File: tb/sim_fec_status_ctl.sv
module sim_fec_status_ctl;
    localparam int NG = 4;
    localparam int GW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    enc_mode = 2'd0;
    logic [GW-1:0] grp = '0;
    logic          stb = 1'b0;
    logic [7:0]    rbyte = 8'h00;
    logic          row = 1'b0;
    logic          byp = 1'b0;
    logic [7:0]    tx_byte;
    logic [1:0]    enc_st, dec_st;
    logic          enc_dly, corr, dec_dly, hit, inv;

    int checks = 0;
    int fails  = 0;

    int m_enc, m_dec;
    bit m_pend, m_hit, m_inv;

    always #2.5 clk = ~clk;

    fec_status_ctl #(.NUM_GROUPS(NG)) u0 (
        .clk(clk), .rst(rst), .enc_mode_i(enc_mode), .tx_group_i(grp),
        .tx_status_byte_o(tx_byte), .enc_state_o(enc_st), .enc_delay_sel_o(enc_dly),
        .rx_status_stb_i(stb), .rx_status_byte_i(rbyte), .row_start_i(row),
        .dec_bypass_i(byp), .dec_state_o(dec_st), .dec_corr_en_o(corr),
        .dec_delay_sel_o(dec_dly), .hitless_o(hit), .rx_invalid_o(inv)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_tx_byte(input int st, input int g);
        return (g == 0 && st == 1) ? 1 : 0;
    endfunction

    function automatic int exp_keep(input int st);
        return (st == 1 || st == 2) ? 1 : 0;
    endfunction

    task automatic check_all();
        chk("R2 enc_state", enc_st, m_enc);
        chk("R3 tx_byte", tx_byte, exp_tx_byte(m_enc, grp));
        chk("R4 enc_delay", enc_dly, exp_keep(m_enc));
        chk("R7 dec_state", dec_st, m_dec);
        chk("R8 hitless", hit, m_hit);
        chk("R6 invalid", inv, m_inv);
        chk("R10 corr_en", corr, (m_dec == 1) ? 1 : 0);
        chk("R10 dec_delay", dec_dly, exp_keep(m_dec));
    endtask

    // drive at negedge, update model, step one edge, compare at next negedge
    task automatic cyc(input logic [1:0] md, input int g, input bit s,
                       input logic [7:0] b, input bit r, input bit y);
        int  n_dec;
        bit  n_pend;
        enc_mode = md; grp = GW'(g); stb = s; rbyte = b; row = r; byp = y;
        n_pend = m_pend;
        if (s && b[1:0] == 2'b01) n_pend = 1;
        if (s && b[1:0] == 2'b00) n_pend = 0;
        if (y)              n_dec = 3;
        else if (m_dec == 3) n_dec = 2;
        else if (r)          n_dec = m_pend ? 1 : 2;
        else                 n_dec = m_dec;
        m_hit = (n_dec != m_dec) && n_dec != 3 && m_dec != 3;
        m_inv = s && b[1];
        if (md != 2'd0) m_enc = md;
        m_dec = n_dec;
        m_pend = n_pend;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin : wd
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd24681);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 enc_state", enc_st, 2);
        chk("R1 dec_state", dec_st, 2);
        chk("R1 hitless", hit, 0);
        chk("R1 invalid", inv, 0);
        chk("R1 tx_byte", tx_byte, 0);
        rst = 1'b0;
        m_enc = 2; m_dec = 2; m_pend = 0; m_hit = 0; m_inv = 0;

        // directed: status "on" with noisy upper bits, then row boundary (R5, R7, R8)
        cyc(2'd1, 0, 1, 8'hFD, 0, 0);
        chk("R3 group0 on byte", tx_byte, 8'h01);
        cyc(2'd0, 1, 0, 8'h00, 0, 0);
        chk("R3 other group zero", tx_byte, 8'h00);
        chk("R7 no change mid row", dec_st, 2);
        cyc(2'd0, 0, 0, 8'h00, 1, 0);
        chk("R8 hitless into state 1", hit, 1);
        // R6: invalid code keeps "on" stored
        cyc(2'd0, 0, 1, 8'h02, 0, 0);
        chk("R6 invalid pulse", inv, 1);
        cyc(2'd0, 0, 1, 8'h03, 1, 0);
        chk("R6 state kept", dec_st, 1);
        // R9: bypass with row start at same time, then release
        cyc(2'd3, 0, 1, 8'h00, 1, 1);
        chk("R9 bypass entered", dec_st, 3);
        chk("R4 enc bypass delay off", enc_dly, 0);
        cyc(2'd0, 0, 0, 8'h00, 1, 0);
        chk("R9 release to 2", dec_st, 2);
        chk("R8 no flag on release", hit, 0);

        // random
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] md;
            int g;
            bit s, r, y;
            logic [7:0] b;
            md = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) md = 2'd0;
            g = int'($urandom_range(0, NG - 1));
            s = ($urandom_range(0, 3) == 0);
            b = 8'($urandom);
            if ($urandom_range(0, 1) == 0) b[1] = 1'b0;
            r = ($urandom_range(0, 3) == 0);
            y = ($urandom_range(0, 19) == 0);
            cyc(md, g, s, b, r, y);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule